// File: doc/BRIEF.md
# Banked Data Memory Address Decoder

This block sits between the load/store path of a small 8-bit controller core and its data storage. It takes an 8-bit data address and resolves it to a physical location. Addresses with bit 7 clear fall in a banked RAM window. The bank is chosen by a bank-select byte that lives at address 0xFF, the last of sixteen scratch registers at 0xF0 to 0xFF. Addresses with bit 7 set reach one shared control area, which stays visible whichever bank is selected. Software can therefore copy data between banks through the scratch registers.

Any access that the core flags as a stack access ignores the bank-select byte and lands in bank 0. Bank 0 gives fewer bytes to the window than the other banks do. Reads of its missing top locations, and reads through a bank-select value that names no fitted bank, return 0xFF; writes to such locations are discarded. A build parameter turns banking off. The bank-select byte is then an ordinary register, and the whole low half maps to bank 0.

Writes are stored on the clock edge while the write strobe is high. Read data is combinational from the stored contents.

Top module: `dmem_banked_top`

## Requirements
- R1: After reset every stored byte, including the bank-select byte at 0xFF, reads as 0x00.
- R2: With banking on and no stack qualifier, an address below 0x80 selects bank `S` (the byte at 0xFF) at offset addr[6:0]. `tgt_bank` reports that bank, `tgt_off` reports the offset, and `tgt_valid` is 1 when the location exists.
- R3: Addresses 0x80 to 0xFF reach one shared area whatever the value of `S`. A byte written there with one bank selected reads back unchanged with any other bank selected.
- R4: When `stack_acc` is 1, a low-half access goes to bank 0 regardless of `S`.
- R5: In bank 0, offsets at or above `BANK0_BYTES` (default 112, so 0x70 to 0x7F) are absent. Reads there return 0xFF, writes are discarded, and `tgt_valid` is 0.
- R6: When `S` is not below `NUM_BANKS`, low-half reads return 0xFF and low-half writes change no bank.
- R7: The same offset in different banks holds independent bytes.
- R8: A write is visible on `rd_data` from the clock edge that captures it. Before that edge, the old value is shown.
- R9: While `rd_en` is 0, `rd_data` is 0x00.
- R10: With `BANKING_EN` = 0, the byte at 0xFF is stored and read like any register but has no effect on mapping. All low-half accesses go to bank 0.
- R11: The bank-select byte changes only through a write to address 0xFF. The new bank applies from the next access after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Data address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| stack_acc | input | 1 | Access is made through the stack pointer |
| rd_data | output | 8 | Read data (0x00 when not reading) |
| tgt_bank | output | $clog2(NUM_BANKS) | Physical bank of a valid low-half access, else 0 |
| tgt_off | output | 7 | Offset within the bank or shared area |
| tgt_valid | output | 1 | The addressed location exists |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high together except in the single-cycle write-then-read check. They also assume that address and strobes settle between clock edges. The bench drives every input on the falling edge and samples one time unit later, so each input is stable across the rising edge. Checks of ignored writes read the location back through the normal read port, after the write and before any other write.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
    typedef logic [7:0] byte_t;
    localparam byte_t DM_ABSENT   = 8'hFF;
    localparam byte_t DM_SEL_ADDR = 8'hFF;
    localparam int    DM_HALF     = 128;
endpackage

// File: rtl/dmem_addr_map.sv
module dmem_addr_map
    import dmem_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK0_BYTES = 112,
    parameter bit BANKING_EN  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  byte_t      addr,
    input  logic       stack_acc,
    input  byte_t      sel_q,
    output logic       is_upper,
    output byte_t      bank_idx,
    output logic [6:0] off,
    output logic       loc_valid
);
    always_comb begin
        is_upper = addr[7];
        off      = addr[6:0];
        bank_idx = (BANKING_EN && !stack_acc) ? sel_q : 8'h00;
        if (is_upper) begin
            loc_valid = 1'b1;
        end else if (bank_idx >= 8'(NUM_BANKS)) begin
            loc_valid = 1'b0;
        end else if (bank_idx == 8'h00) begin
            loc_valid = (32'(off) < BANK0_BYTES);
        end else begin
            loc_valid = 1'b1;
        end
    end

    // R4: stack accesses map to bank 0
    a_r4_stack_bank0: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_acc && !addr[7]) |-> (bank_idx == 8'h00));
    // R5: missing top of bank 0 is invalid
    a_r5_bank0_hole: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr[7] && bank_idx == 8'h00 && 32'(addr[6:0]) >= BANK0_BYTES) |-> !loc_valid);
    // R3: shared area always present
    a_r3_upper_valid: assert property (@(posedge clk) disable iff (!rst_n)
        addr[7] |-> loc_valid);
    // R2: banked low half follows the select byte
    a_r2_follow_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (BANKING_EN && !stack_acc && !addr[7]) |-> (bank_idx == sel_q));
endmodule

// File: rtl/dmem_bank_store.sv
module dmem_bank_store
    import dmem_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  byte_t         wdata,
    output byte_t         rdata
);
    byte_t mem_d [DEPTH];
    byte_t mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we && (32'(idx) < DEPTH)) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) mem_q[i] <= 8'h00;
            else        mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = (32'(idx) < DEPTH) ? mem_q[idx] : DM_ABSENT;
endmodule

// File: rtl/dmem_banked_top.sv
module dmem_banked_top
    import dmem_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK0_BYTES = 112,
    parameter bit BANKING_EN  = 1'b1,
    localparam int BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int UPPER_DEPTH = DM_HALF - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              stack_acc,
    output logic [7:0]        rd_data,
    output logic [BANK_W-1:0] tgt_bank,
    output logic [6:0]        tgt_off,
    output logic              tgt_valid
);
    typedef struct packed {
        byte_t sel;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       is_upper, loc_valid, sel_hit;
    byte_t      bank_idx, upper_rd;
    logic [6:0] off;
    logic [NUM_BANKS-1:0] bank_we;
    byte_t      bank_rd [NUM_BANKS];

    dmem_addr_map #(
        .NUM_BANKS(NUM_BANKS), .BANK0_BYTES(BANK0_BYTES), .BANKING_EN(BANKING_EN)
    ) u_map (
        .clk(clk), .rst_n(rst_n), .addr(addr), .stack_acc(stack_acc),
        .sel_q(st_q.sel), .is_upper(is_upper), .bank_idx(bank_idx),
        .off(off), .loc_valid(loc_valid)
    );

    assign sel_hit = (addr == DM_SEL_ADDR);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int DEPTH_G = (g == 0) ? BANK0_BYTES : DM_HALF;
        localparam int AW_G    = (DEPTH_G > 1) ? $clog2(DEPTH_G) : 1;
        assign bank_we[g] = wr_en && loc_valid && !is_upper && (bank_idx == 8'(g));
        dmem_bank_store #(.DEPTH(DEPTH_G)) u_store (
            .clk(clk), .rst_n(rst_n), .we(bank_we[g]),
            .idx(AW_G'(off)), .wdata(wr_data), .rdata(bank_rd[g])
        );
    end

    dmem_bank_store #(.DEPTH(UPPER_DEPTH)) u_upper (
        .clk(clk), .rst_n(rst_n), .we(wr_en && is_upper && !sel_hit),
        .idx(off), .wdata(wr_data), .rdata(upper_rd)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en && sel_hit) st_d.sel = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            if (!loc_valid)    rd_data = DM_ABSENT;
            else if (sel_hit)  rd_data = st_q.sel;
            else if (is_upper) rd_data = upper_rd;
            else begin
                for (int b = 0; b < NUM_BANKS; b++)
                    if (bank_idx == 8'(b)) rd_data = bank_rd[b];
            end
        end
    end

    assign tgt_valid = loc_valid;
    assign tgt_off   = off;
    assign tgt_bank  = (loc_valid && !is_upper) ? BANK_W'(bank_idx) : '0;

    // R9: idle read port returns zero
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == 8'h00));
    // R11: select byte changes only by a write to 0xFF
    a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == DM_SEL_ADDR) |=> $stable(st_q.sel));
    // R5/R6: absent locations read all-ones
    a_r6_absent_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !tgt_valid) |-> (rd_data == DM_ABSENT));
    // R6: no bank is written through an invalid location
    a_r6_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_valid |-> (bank_we == '0));
endmodule

// File: tb/tb_dmem_banked_top.sv
module tb_dmem_banked_top;
    localparam int NV = 25;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] addr = 8'h00, wr_data = 8'h00, rd_data;
    logic rd_en = 1'b0, wr_en = 1'b0, stack_acc = 1'b0;
    logic [1:0] tgt_bank;
    logic [6:0] tgt_off;
    logic tgt_valid;
    logic [7:0] nb_addr = 8'h00, nb_wd = 8'h00, nb_rd;
    logic nb_re = 1'b0, nb_we = 1'b0;
    logic [1:0] nb_bank;
    logic [6:0] nb_off;
    logic nb_valid;
    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dmem_banked_top dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .stack_acc(stack_acc), .rd_data(rd_data),
        .tgt_bank(tgt_bank), .tgt_off(tgt_off), .tgt_valid(tgt_valid)
    );

    dmem_banked_top #(.BANKING_EN(1'b0)) dut_nb (
        .clk(clk), .rst_n(rst_n), .addr(nb_addr), .rd_en(nb_re), .wr_en(nb_we),
        .wr_data(nb_wd), .stack_acc(1'b0), .rd_data(nb_rd),
        .tgt_bank(nb_bank), .tgt_off(nb_off), .tgt_valid(nb_valid)
    );

    // {write, stack, addr, data, expected, requirement}
    localparam logic [33:0] VEC [NV] = '{
        {1'b1,1'b0,8'hFF,8'h01,8'h00,8'd11}, // R11 select bank 1
        {1'b1,1'b0,8'h20,8'hA1,8'h00,8'd7},
        {1'b1,1'b0,8'hFF,8'h02,8'h00,8'd11},
        {1'b1,1'b0,8'h20,8'hA2,8'h00,8'd7},
        {1'b0,1'b0,8'h20,8'h00,8'hA2,8'd7},  // R7 bank 2
        {1'b1,1'b0,8'hFF,8'h01,8'h00,8'd11},
        {1'b0,1'b0,8'h20,8'h00,8'hA1,8'd7},  // R7 bank 1 kept
        {1'b1,1'b0,8'hF3,8'h5C,8'h00,8'd3},
        {1'b1,1'b0,8'hFF,8'h03,8'h00,8'd11},
        {1'b0,1'b0,8'hF3,8'h00,8'h5C,8'd3},  // R3 shared area
        {1'b0,1'b1,8'h20,8'h00,8'h00,8'd4},  // R4 stack read bank 0
        {1'b1,1'b1,8'h30,8'h77,8'h00,8'd4},
        {1'b0,1'b0,8'h30,8'h00,8'h00,8'd4},  // R4 bank 3 untouched
        {1'b1,1'b0,8'hFF,8'h00,8'h00,8'd11},
        {1'b0,1'b0,8'h30,8'h00,8'h77,8'd4},  // R4 landed in bank 0
        {1'b1,1'b0,8'h75,8'h99,8'h00,8'd5},
        {1'b0,1'b0,8'h75,8'h00,8'hFF,8'd5},  // R5 hole
        {1'b1,1'b0,8'hFF,8'h07,8'h00,8'd6},
        {1'b0,1'b0,8'h20,8'h00,8'hFF,8'd6},  // R6 no bank 7
        {1'b1,1'b0,8'h20,8'hEE,8'h00,8'd6},
        {1'b1,1'b0,8'hFF,8'h02,8'h00,8'd6},
        {1'b0,1'b0,8'h20,8'h00,8'hA2,8'd6},  // R6 bank 2 kept
        {1'b1,1'b0,8'hFF,8'h00,8'h00,8'd6},
        {1'b0,1'b0,8'h20,8'h00,8'h00,8'd6},  // R6 bank 0 kept
        {1'b0,1'b0,8'hFF,8'h00,8'h00,8'd11}  // R11 select reads back
    };

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input int req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stk);
        @(negedge clk);
        addr = a; wr_data = d; stack_acc = stk; rd_en = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; stack_acc = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic stk, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr = a; stack_acc = stk; rd_en = 1'b1; wr_en = 1'b0;
        #1 check(rd_data, exp, req);
        rd_en = 1'b0; stack_acc = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(8'h00, 1'b0, 8'h00, 1);
        rd(8'hFF, 1'b0, 8'h00, 1);
        rd(8'h90, 1'b0, 8'h00, 1);
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][33]) wr(VEC[i][31:24], VEC[i][23:16], VEC[i][32]);
            else rd(VEC[i][31:24], VEC[i][32], VEC[i][15:8], int'(VEC[i][7:0]));
        end
        // R9 idle read port
        @(negedge clk); addr = 8'hF3; rd_en = 1'b0;
        #1 check(rd_data, 8'h00, 9);
        // R2 target outputs with S=2
        wr(8'hFF, 8'h02, 1'b0);
        @(negedge clk); addr = 8'h45;
        #1 check({6'd0, tgt_bank}, 8'h02, 2);
        check({1'b0, tgt_off}, 8'h45, 2);
        check({7'd0, tgt_valid}, 8'h01, 2);
        // R5 hole flagged invalid in bank 0
        wr(8'hFF, 8'h00, 1'b0);
        @(negedge clk); addr = 8'h7F;
        #1 check({7'd0, tgt_valid}, 8'h00, 5);
        // R8 write visible from the capturing edge
        @(negedge clk); addr = 8'h50; wr_data = 8'h3C; wr_en = 1'b1; rd_en = 1'b1;
        #1 check(rd_data, 8'h00, 8);
        @(posedge clk); #1 check(rd_data, 8'h3C, 8);
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        // R10 banking off
        @(negedge clk); nb_addr = 8'hFF; nb_wd = 8'h02; nb_we = 1'b1;
        @(negedge clk); nb_addr = 8'h20; nb_wd = 8'h55;
        @(negedge clk); nb_we = 1'b0; nb_re = 1'b1; nb_addr = 8'hFF;
        #1 check(nb_rd, 8'h02, 10);
        @(negedge clk); nb_addr = 8'h20;
        #1 check(nb_rd, 8'h55, 10);
        check({6'd0, nb_bank}, 8'h00, 10);
        nb_re = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule